// File: doc/BRIEF.md
# Management-Bus Transceiver Discovery and Port Selection

This block runs once per `start` pulse. It finds the Ethernet transceivers attached to a shared management bus and chooses one of them as the active port. It does not drive the serial bus itself. Each register access goes out as a request to a separate management engine. The request carries the device address, register number, a write flag and write data. The engine finishes each access with a one-cycle acknowledge and, for reads, returns 16-bit data.

The block works in three phases. First it probes every address and classifies each device that answers, using its identifier registers and a small table of known devices. Next it walks the responding devices from the highest address down to the lowest. The first device with link up is taken as the default. Every other device it visits is put into isolation with auto-negotiation enabled. Last, the block takes the chosen device out of isolation, reads its status and reports the result. `done` pulses at the end. `found`, `sel_addr` and `link_up` keep their values until the next `start`.

Top module: `phy_scan_ctrl`

## Requirements
- R1: After `start`, every address from 0 to 31 is probed with two back-to-back reads of the status register (register 1). Only the second value is used.
- R2: A second status value of 0xFFFF or 0x0000 marks the address as empty. An empty address gets no identifier reads, and no device is recorded there.
- R3: A responding device gets one read of register 2 and one of register 3. It is classified by matching register 2 exactly and register 3 ANDed with 0xFFF0 against the known-device table. A mixed entry is classed LAN when status bit 14 or bit 13 is set, and home otherwise. A device with no match is neither home nor LAN.
- R4: The walk visits the recorded devices from the highest address to the lowest. At each device it reads status twice. The first device whose second value has bit 2 (link) set becomes the default.
- R5: Every device visited in the walk that is not taken as the default gets a read of the control register (register 0), then a write of the same value with bits 12 (auto-negotiation) and 10 (isolate) set.
- R6: If no device has link, the selected device is the home-class device visited last in the walk (the lowest-addressed one). If there is no home-class device, the highest-addressed device is selected.
- R7: For the selected device, the control register is read and written back with bit 10 cleared and all other bits kept. Status is then read twice, and `link_up` takes bit 2 of the second value.
- R8: `done` is high for exactly one cycle per run. When any device was found, `found` is high and `sel_addr` holds the selected address. When none was found, `found` and `link_up` are low and no write is issued.
- R9: Once `mgmt_req` is raised, it stays high and its address, register, write flag and data stay unchanged until `mgmt_ack`. Each acknowledge completes exactly one access.
- R10: During reset and until the first run completes, `done`, `found`, `link_up`, `mgmt_req` and `sel_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a discovery run when idle |
| mgmt_req | output | 1 | Access request to the management engine |
| mgmt_we | output | 1 | 1 = write access, 0 = read access |
| mgmt_phy | output | 5 | Target device address |
| mgmt_reg | output | 5 | Target register number |
| mgmt_wdata | output | 16 | Write data |
| mgmt_ack | input | 1 | One-cycle completion of the current access |
| mgmt_rdata | input | 16 | Read data, valid with `mgmt_ack` |
| sel_addr | output | 5 | Address of the selected device |
| found | output | 1 | At least one device responded |
| link_up | output | 1 | Link state of the selected device |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The device model answers the first status read of every pair with 0xFFFF. A design that used the first value would therefore find nothing. The bench runs several bus populations, each chosen so that one selection tier decides the outcome:
- An empty bus with one zero-status device shows that absent devices are rejected and that no write is issued.
- A lone device with no identifier match exercises the fall-back to the head of the list.
- Two linked devices separate "first in walk order" from "lowest address".
- A set of home-class devices, plus a device that matches only in unmasked bits, shows that the last home device is remembered and that the masked identifier match is correct.
- Mixed-class devices with different speed bits show that the LAN/home split follows status bits 14 and 13.

The final control-register values of every device show which devices were isolated and which were released.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

  localparam int DATA_W = 16;
  localparam int REG_W  = 5;

  // management register numbers
  localparam logic [REG_W-1:0] REG_CTRL = 5'd0;
  localparam logic [REG_W-1:0] REG_STAT = 5'd1;
  localparam logic [REG_W-1:0] REG_ID_A = 5'd2;
  localparam logic [REG_W-1:0] REG_ID_B = 5'd3;

  // bit positions inside status and control
  localparam int STAT_LINK_BIT  = 2;
  localparam int STAT_TXFD_BIT  = 14;
  localparam int STAT_TXHD_BIT  = 13;
  localparam logic [DATA_W-1:0] CTRL_AN_MASK  = 16'h1000;
  localparam logic [DATA_W-1:0] CTRL_ISO_MASK = 16'h0400;
  localparam logic [DATA_W-1:0] ID_B_MASK     = 16'hFFF0;

  typedef enum logic [1:0] {
    KIND_UNKNOWN = 2'd0,
    KIND_HOME    = 2'd1,
    KIND_LAN     = 2'd2,
    KIND_MIX     = 2'd3
  } phy_kind_e;

  typedef struct packed {
    logic [DATA_W-1:0] id_a;
    logic [DATA_W-1:0] id_b;
    phy_kind_e         kind;
  } known_dev_t;

  localparam int KNOWN_N = 3;

  function automatic known_dev_t known_entry(input int idx);
    known_dev_t e;
    case (idx)
      0:       e = '{id_a: 16'h0123, id_b: 16'h4560, kind: KIND_HOME};
      1:       e = '{id_a: 16'h0123, id_b: 16'h4570, kind: KIND_LAN};
      default: e = '{id_a: 16'h0ABC, id_b: 16'hDE00, kind: KIND_MIX};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/phy_classify.sv
module phy_classify
  import phy_scan_pkg::*;
(
  input  logic [DATA_W-1:0] id_a_i,
  input  logic [DATA_W-1:0] id_b_i,
  input  logic [DATA_W-1:0] stat_i,
  output phy_kind_e         kind_o
);

  known_dev_t ent;
  logic       hit;

  always_comb begin
    hit    = 1'b0;
    kind_o = KIND_UNKNOWN;
    ent    = known_entry(0);
    for (int i = 0; i < KNOWN_N; i++) begin
      ent = known_entry(i);
      if (!hit && (id_a_i == ent.id_a) && ((id_b_i & ID_B_MASK) == ent.id_b)) begin
        hit    = 1'b1;
        kind_o = ent.kind;
      end
    end
    if (kind_o == KIND_MIX) begin
      kind_o = (stat_i[STAT_TXFD_BIT] || stat_i[STAT_TXHD_BIT]) ? KIND_LAN : KIND_HOME;
    end
  end

endmodule

// File: rtl/phy_table.sv
module phy_table
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  phy_kind_e              wr_kind_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output phy_kind_e              rd_kind_o,
  output logic [(1<<ADDR_W)-1:0] valid_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] valid_q, valid_d;
  phy_kind_e        kind_q [DEPTH];

  always_comb begin
    valid_d = valid_q;
    if (clr_i) begin
      valid_d = '0;
    end else if (wr_en_i) begin
      valid_d[wr_addr_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // datapath storage, no reset: only read where valid_q is set
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en_i && (wr_addr_i == ADDR_W'(i))) begin
        kind_q[i] <= wr_kind_i;
      end
    end
  end

  assign rd_kind_o = kind_q[rd_addr_i];
  assign valid_o   = valid_q;

  // R2: a new run starts with an empty table
  a_r2_table_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_q == '0));

endmodule

// File: rtl/phy_scan_ctrl.sv
module phy_scan_ctrl
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mgmt_req,
  output logic              mgmt_we,
  output logic [ADDR_W-1:0] mgmt_phy,
  output logic [REG_W-1:0]  mgmt_reg,
  output logic [DATA_W-1:0] mgmt_wdata,
  input  logic              mgmt_ack,
  input  logic [DATA_W-1:0] mgmt_rdata,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              found,
  output logic              link_up,
  output logic              done
);

  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [4:0] {
    S_IDLE, S_PRB_A, S_PRB_B, S_ID_A, S_ID_B, S_NEXT,
    S_WALK, S_WST_A, S_WST_B, S_WCT_RD, S_WCT_WR,
    S_SEL, S_FCT_RD, S_FCT_WR, S_FST_A, S_FST_B, S_DONE
  } st_e;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  st_e               state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, def_q, def_d, home_q, home_d;
  logic [ADDR_W-1:0] head_q, head_d, sel_q, sel_d;
  logic              have_def_q, have_def_d, have_home_q, have_home_d;
  logic              found_q, found_d, link_q, link_d;
  logic [DATA_W-1:0] stat_q, stat_d, ida_q, ida_d, ctrl_q, ctrl_d;
  logic              tab_clr, tab_wr, stat_empty, ptr_low;
  phy_kind_e         new_kind, walk_kind;
  logic [DEPTH-1:0]  valid;

  phy_classify u_classify (
    .id_a_i (ida_q),
    .id_b_i (mgmt_rdata),
    .stat_i (stat_q),
    .kind_o (new_kind)
  );

  phy_table #(.ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (tab_clr),
    .wr_en_i   (tab_wr),
    .wr_addr_i (ptr_q),
    .wr_kind_i (new_kind),
    .rd_addr_i (ptr_q),
    .rd_kind_o (walk_kind),
    .valid_o   (valid)
  );

  assign stat_empty = (mgmt_rdata == '1) || (mgmt_rdata == '0);
  assign ptr_low    = (ptr_q == '0);

  // next-state process
  always_comb begin
    state_d     = state_q;
    ptr_d       = ptr_q;
    def_d       = def_q;
    home_d      = home_q;
    head_d      = head_q;
    sel_d       = sel_q;
    have_def_d  = have_def_q;
    have_home_d = have_home_q;
    found_d     = found_q;
    link_d      = link_q;
    stat_d      = stat_q;
    ida_d       = ida_q;
    ctrl_d      = ctrl_q;
    tab_clr     = 1'b0;
    tab_wr      = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        tab_clr     = 1'b1;
        ptr_d       = '0;
        sel_d       = '0;
        found_d     = 1'b0;
        link_d      = 1'b0;
        have_def_d  = 1'b0;
        have_home_d = 1'b0;
        state_d     = S_PRB_A;
      end
      S_PRB_A: if (mgmt_ack) state_d = S_PRB_B;
      S_PRB_B: if (mgmt_ack) begin
        stat_d  = mgmt_rdata;
        state_d = stat_empty ? S_NEXT : S_ID_A;
      end
      S_ID_A: if (mgmt_ack) begin
        ida_d   = mgmt_rdata;
        state_d = S_ID_B;
      end
      S_ID_B: if (mgmt_ack) begin
        tab_wr  = 1'b1;
        head_d  = ptr_q;           // list head = last device found
        state_d = S_NEXT;
      end
      S_NEXT: begin
        if (ptr_q == '1) begin
          state_d = (|valid) ? S_WALK : S_DONE;   // walk starts at top address
        end else begin
          ptr_d   = ptr_q + 1'b1;
          state_d = S_PRB_A;
        end
      end
      S_WALK: begin
        if (valid[ptr_q])  state_d = S_WST_A;
        else if (ptr_low)  state_d = S_SEL;
        else               ptr_d   = ptr_q - 1'b1;
      end
      S_WST_A: if (mgmt_ack) state_d = S_WST_B;
      S_WST_B: if (mgmt_ack) begin
        if (mgmt_rdata[STAT_LINK_BIT] && !have_def_q) begin
          def_d      = ptr_q;
          have_def_d = 1'b1;
          if (ptr_low) state_d = S_SEL;
          else begin ptr_d = ptr_q - 1'b1; state_d = S_WALK; end
        end else begin
          state_d = S_WCT_RD;
        end
      end
      S_WCT_RD: if (mgmt_ack) begin
        ctrl_d  = mgmt_rdata;
        state_d = S_WCT_WR;
      end
      S_WCT_WR: if (mgmt_ack) begin
        if (walk_kind == KIND_HOME) begin
          home_d      = ptr_q;
          have_home_d = 1'b1;
        end
        if (ptr_low) state_d = S_SEL;
        else begin ptr_d = ptr_q - 1'b1; state_d = S_WALK; end
      end
      S_SEL: begin
        sel_d   = have_def_q ? def_q : (have_home_q ? home_q : head_q);
        state_d = S_FCT_RD;
      end
      S_FCT_RD: if (mgmt_ack) begin
        ctrl_d  = mgmt_rdata;
        state_d = S_FCT_WR;
      end
      S_FCT_WR: if (mgmt_ack) state_d = S_FST_A;
      S_FST_A:  if (mgmt_ack) state_d = S_FST_B;
      S_FST_B:  if (mgmt_ack) begin
        link_d  = mgmt_rdata[STAT_LINK_BIT];
        found_d = 1'b1;
        state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= S_IDLE;
      ptr_q       <= '0;
      def_q       <= '0;
      home_q      <= '0;
      head_q      <= '0;
      sel_q       <= '0;
      have_def_q  <= 1'b0;
      have_home_q <= 1'b0;
      found_q     <= 1'b0;
      link_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      ptr_q       <= ptr_d;
      def_q       <= def_d;
      home_q      <= home_d;
      head_q      <= head_d;
      sel_q       <= sel_d;
      have_def_q  <= have_def_d;
      have_home_q <= have_home_d;
      found_q     <= found_d;
      link_q      <= link_d;
    end
  end

  // datapath capture registers, enabled by acknowledge
  always_ff @(posedge clk) begin
    if (mgmt_ack) begin
      stat_q <= stat_d;
      ida_q  <= ida_d;
      ctrl_q <= ctrl_d;
    end
  end

  // management request decode
  always_comb begin
    mgmt_req   = 1'b0;
    mgmt_we    = 1'b0;
    mgmt_phy   = ptr_q;
    mgmt_reg   = REG_STAT;
    mgmt_wdata = '0;
    case (state_q)
      S_PRB_A, S_PRB_B, S_WST_A, S_WST_B: mgmt_req = 1'b1;
      S_ID_A:   begin mgmt_req = 1'b1; mgmt_reg = REG_ID_A; end
      S_ID_B:   begin mgmt_req = 1'b1; mgmt_reg = REG_ID_B; end
      S_WCT_RD: begin mgmt_req = 1'b1; mgmt_reg = REG_CTRL; end
      S_WCT_WR: begin
        mgmt_req   = 1'b1;
        mgmt_we    = 1'b1;
        mgmt_reg   = REG_CTRL;
        mgmt_wdata = ctrl_q | CTRL_AN_MASK | CTRL_ISO_MASK;
      end
      S_FCT_RD: begin mgmt_req = 1'b1; mgmt_reg = REG_CTRL; mgmt_phy = sel_q; end
      S_FCT_WR: begin
        mgmt_req   = 1'b1;
        mgmt_we    = 1'b1;
        mgmt_reg   = REG_CTRL;
        mgmt_phy   = sel_q;
        mgmt_wdata = ctrl_q & ~CTRL_ISO_MASK;
      end
      S_FST_A, S_FST_B: begin mgmt_req = 1'b1; mgmt_phy = sel_q; end
      default: ;
    endcase
  end

  assign sel_addr = sel_q;
  assign found    = found_q;
  assign link_up  = link_q;
  assign done     = (state_q == S_DONE);

  // R9: request fields hold until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_phy) && $stable(mgmt_reg)
                                 && $stable(mgmt_we) && $stable(mgmt_wdata)));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R8: found agrees with the discovery table at the end of a run
  a_r8_found_match: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (found == (|valid)));

  // R6: the selected address is always a recorded device
  a_r6_sel_recorded: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && found) |-> valid[sel_addr]);

  // R5: walk accesses only target recorded devices
  a_r5_walk_target: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mgmt_req && (state_q inside {S_WST_A, S_WST_B, S_WCT_RD, S_WCT_WR}))
      |-> valid[mgmt_phy]);

endmodule

// File: tb/phy_scan_ctrl_tb_top.sv
module phy_scan_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mgmt_req, mgmt_we;
  logic [4:0]  mgmt_phy, mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic        mgmt_ack = 1'b0;
  logic [15:0] mgmt_rdata = 16'h0;
  logic [4:0]  sel_addr;
  logic        found, link_up, done;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  phy_scan_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_phy(mgmt_phy),
    .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
    .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata),
    .sel_addr(sel_addr), .found(found), .link_up(link_up), .done(done)
  );

  // ---------------- device model ----------------
  bit          m_here [32];
  logic [15:0] m_stat [32];
  logic [15:0] m_ida  [32];
  logic [15:0] m_idb  [32];
  logic [15:0] m_ctrl [32];
  int          n_stat_rd [32];
  int          n_id_rd   [32];
  int          n_ctrl_wr [32];
  int          n_wr = 0;
  int          proto_err = 0;
  int          ph = 0;
  logic [4:0]  l_phy, l_reg, last_phy;
  logic        l_we;
  logic [15:0] l_wd;
  bit          last_stat_rd = 1'b0;

  function automatic logic [15:0] read_val(input logic [4:0] p, input logic [4:0] r, input bit fresh);
    if (!m_here[p]) return 16'hFFFF;
    case (r)
      5'd0:    return m_ctrl[p];
      5'd1:    return fresh ? m_stat[p] : 16'hFFFF;   // first read of a pair is stale
      5'd2:    return m_ida[p];
      5'd3:    return m_idb[p];
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    mgmt_ack <= 1'b0;
    case (ph)
      0: if (mgmt_req) begin
        l_phy <= mgmt_phy; l_reg <= mgmt_reg; l_we <= mgmt_we; l_wd <= mgmt_wdata;
        ph <= 1;
      end
      1, 2: begin
        if (!mgmt_req || mgmt_phy != l_phy || mgmt_reg != l_reg || mgmt_we != l_we ||
            (l_we && mgmt_wdata != l_wd)) proto_err++;
        if (ph == 2) begin
          mgmt_ack <= 1'b1;
          if (l_we) begin
            n_wr++;
            if (l_reg == 5'd0) begin
              m_ctrl[l_phy] <= l_wd;
              n_ctrl_wr[l_phy]++;
            end
            last_stat_rd = 1'b0;
          end else begin
            mgmt_rdata <= read_val(l_phy, l_reg, last_stat_rd && last_phy == l_phy);
            if (l_reg == 5'd1) n_stat_rd[l_phy]++;
            if (l_reg == 5'd2 || l_reg == 5'd3) n_id_rd[l_phy]++;
            last_stat_rd = (l_reg == 5'd1) && !(last_stat_rd && last_phy == l_phy);
          end
          last_phy = l_phy;
          ph <= 3;
        end else ph <= 2;
      end
      default: ph <= 0;
    endcase
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_bus();
    for (int i = 0; i < 32; i++) begin
      m_here[i] = 1'b0; m_stat[i] = 16'hFFFF; m_ida[i] = 16'h0; m_idb[i] = 16'h0;
      m_ctrl[i] = 16'h0; n_stat_rd[i] = 0; n_id_rd[i] = 0; n_ctrl_wr[i] = 0;
    end
    n_wr = 0; proto_err = 0;
  endtask

  task automatic add_dev(input int a, input logic [15:0] ida, input logic [15:0] idb,
                         input logic [15:0] st, input logic [15:0] ctl);
    m_here[a] = 1'b1; m_ida[a] = ida; m_idb[a] = idb; m_stat[a] = st; m_ctrl[a] = ctl;
  endtask

  task automatic run_scan();
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 50000) begin @(negedge clk); n++; end
    if (!done) check("R8 run timeout", 0, 1);
    check("R9 request protocol", proto_err, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R10 done", done, 0);
    check("R10 found", found, 0);
    check("R10 link_up", link_up, 0);
    check("R10 req", mgmt_req, 0);
    check("R10 sel_addr", sel_addr, 0);
  endtask

  task automatic t_empty();
    clear_bus();
    add_dev(10, 16'h0123, 16'h4560, 16'h0000, 16'h0000);   // zero status: not a device
    run_scan();
    check("R8 found low when empty", found, 0);
    check("R8 link low when empty", link_up, 0);
    check("R8 no writes when empty", n_wr, 0);
    check("R1 status reads addr0", n_stat_rd[0], 2);
    check("R1 status reads addr31", n_stat_rd[31], 2);
    check("R2 zero status no id reads", n_id_rd[10], 0);
    check("R2 absent no id reads", n_id_rd[11], 0);
  endtask

  task automatic t_single();
    clear_bus();
    add_dev(5, 16'h7777, 16'h1230, 16'h7809, 16'h0100);
    run_scan();
    check("R1 found with stale first read", found, 1);
    check("R6 head selected", sel_addr, 5);
    check("R7 link_up low", link_up, 0);
    check("R3 id reads", n_id_rd[5], 2);
    check("R5/R7 ctrl writes", n_ctrl_wr[5], 2);
    check("R7 ctrl released", m_ctrl[5], 16'h1100);
  endtask

  task automatic t_linked();
    clear_bus();
    add_dev(3,  16'h0123, 16'h4570, 16'h780D, 16'h0000);
    add_dev(9,  16'h0123, 16'h4570, 16'h780D, 16'h0000);
    add_dev(20, 16'h0123, 16'h4570, 16'h7809, 16'h0000);
    run_scan();
    check("R4 first linked in walk", sel_addr, 9);
    check("R7 link_up high", link_up, 1);
    check("R5 second linked isolated", m_ctrl[3], 16'h1400);
    check("R5 unlinked isolated", m_ctrl[20], 16'h1400);
    check("R7 selected ctrl", m_ctrl[9], 16'h0000);
    check("R7 selected one write", n_ctrl_wr[9], 1);
    check("R8 found", found, 1);
  endtask

  task automatic t_home();
    clear_bus();
    add_dev(1,  16'h0123, 16'h4590, 16'h7809, 16'h0000);   // id_b mismatch
    add_dev(4,  16'h0123, 16'h4563, 16'h7809, 16'h0000);   // home, low nibble masked
    add_dev(12, 16'h0123, 16'h4560, 16'h7809, 16'h0000);   // home
    add_dev(25, 16'h0123, 16'h4570, 16'h7809, 16'h0000);   // lan
    run_scan();
    check("R6 last home selected", sel_addr, 4);
    check("R7 link low", link_up, 0);
    check("R5 other home isolated", m_ctrl[12], 16'h1400);
    check("R3 mismatch isolated", m_ctrl[1], 16'h1400);
    check("R7 home released", m_ctrl[4], 16'h1000);
  endtask

  task automatic t_mix();
    clear_bus();
    add_dev(7, 16'h0ABC, 16'hDE05, 16'h4809, 16'h0000);    // tx full duplex -> lan
    add_dev(2, 16'h0ABC, 16'hDE00, 16'h1809, 16'h0000);    // no tx -> home
    run_scan();
    check("R3 mixed without tx is home", sel_addr, 2);
    clear_bus();
    add_dev(2, 16'h0ABC, 16'hDE00, 16'h2809, 16'h0000);    // tx half duplex -> lan
    add_dev(7, 16'h7777, 16'h1230, 16'h7809, 16'h0000);
    run_scan();
    check("R3 mixed with tx half is lan", sel_addr, 7);
    check("R5 lan isolated", m_ctrl[2], 16'h1400);
  endtask

  initial begin
    clear_bus();
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_empty();
    t_single();
    t_linked();
    t_home();
    t_mix();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule